// File: doc/BRIEF.md
# Legacy Video Window Plane Mapper

This block sits between the host bus decoder and a four-plane video memory. Each plane holds one byte per address, and all four planes share one 64K address space. For every host cycle it takes a 17-bit offset into the 128K legacy window (offset 0 is the first byte at A0000h). It decides whether the access falls inside the decoded window. It forms the 16-bit plane address and then picks which planes a write reaches, or which single plane a read returns.

Three independent controls shape the result. The write odd/even control gates the write enables by host address parity. The read odd/even control replaces the low bit of the read plane index with host address parity. The address chain control replaces plane address bit 0 with a higher bit: offset bit 16 when the full 128K window is decoded, otherwise the page select input. Each control acts only on its own path, so any mix of settings gives a defined result. All outputs are registered and show the result one clock after the inputs are presented.

Top module: `vga_host_plane_map`

## Requirements
- R1: While `rst` is high, on the next rising edge `win_hit`, `plane_addr`, `plane_wr_en` and `rd_plane` all become 0, whatever the inputs are.
- R2: `win_hit` is 1 one clock after an access (`rd_req` or `wr_req` high) whose window address 0xA0000+`host_ofs` falls in the window picked by `map_win`: 2'b00 covers A0000h–BFFFFh, 2'b01 covers A0000h–AFFFFh, 2'b10 covers B0000h–B7FFFh and 2'b11 covers B8000h–BFFFFh. In every other case `win_hit` is 0.
- R3: `plane_wr_en` is 4'b0000 unless `wr_req` was high and the offset was inside the window.
- R4: When a write hits and `wr_flat` is 1, `plane_wr_en` equals `plane_mask`. Bit n of `plane_mask` enables plane n.
- R5: When a write hits and `wr_flat` is 0, `plane_wr_en` equals `plane_mask & 4'b0101` if `host_ofs[0]` is 0, and `plane_mask & 4'b1010` if it is 1.
- R6: `wr_flat` has no effect on `rd_plane`.
- R7: `rd_plane` equals `rd_map` when `rd_oddeven` is 0, and equals {`rd_map[1]`, `host_ofs[0]`} when `rd_oddeven` is 1.
- R8: On a hit with `addr_chain` 0, `plane_addr` is the window-relative byte offset (window address minus window base, low 16 bits), and bit 0 is `host_ofs[0]`.
- R9: On a hit with `addr_chain` 1 and `map_win` 2'b00, `plane_addr[15:1]` is as in R8 and `plane_addr[0]` equals `host_ofs[16]`.
- R10: On a hit with `addr_chain` 1 and `map_win` not 2'b00, `plane_addr[15:1]` is as in R8 and `plane_addr[0]` equals `page_hi` (1 selects the high page).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ofs | input | 17 | Host offset from A0000h |
| rd_req | input | 1 | Host read strobe |
| wr_req | input | 1 | Host write strobe |
| plane_mask | input | 4 | Planes allowed for writes |
| wr_flat | input | 1 | 1: mask alone selects planes; 0: odd/even write gating |
| rd_map | input | 2 | Plane read when odd/even reads are off |
| rd_oddeven | input | 1 | 1: host A0 picks the odd or even read plane |
| map_win | input | 2 | Window decode select |
| addr_chain | input | 1 | 1: replace plane address bit 0 |
| page_hi | input | 1 | Replacement bit for the smaller windows |
| win_hit | output | 1 | Access fell in the window |
| plane_addr | output | 16 | Address within every plane |
| plane_wr_en | output | 4 | Per-plane write enables |
| rd_plane | output | 2 | Index of the plane returned on reads |

## Verification
The hardest cases to reach are the settings that no normal display mode uses. Examples are odd/even writes combined with flat reads, and address chaining in the 128K decode, where the replacement bit comes from host offset bit 16 and not from the page select. The bench sweeps every combination of the window, chain, page, write-mode and read-mode controls with all sixteen masks and all four strobe pairings. It runs these against offsets chosen on each window edge and on both parities, so every mixed combination and every window boundary is applied.

// File: rtl/vga_map_pkg.sv
package vga_map_pkg;
  localparam int PLANES = 4;
  localparam int ADDR_W = 16;
  localparam int OFS_W  = ADDR_W + 1;

  typedef enum logic [1:0] {
    WIN_FULL  = 2'b00,
    WIN_LOW   = 2'b01,
    WIN_MONO  = 2'b10,
    WIN_COLOR = 2'b11
  } win_sel_t;
endpackage

// File: rtl/vga_win_decode.sv
module vga_win_decode #(
  parameter int ADDR_W = 16,
  localparam int OFS_W = ADDR_W + 1
) (
  input  logic [OFS_W-1:0]  ofs,
  input  logic [1:0]        sel,
  output logic              in_win,
  output logic [ADDR_W-1:0] rel
);
  import vga_map_pkg::*;

  always_comb begin
    unique case (win_sel_t'(sel))
      WIN_FULL: begin
        in_win = 1'b1;
        rel    = ofs[ADDR_W-1:0];
      end
      WIN_LOW: begin
        in_win = ~ofs[OFS_W-1];
        rel    = ofs[ADDR_W-1:0];
      end
      WIN_MONO: begin
        in_win = (ofs[OFS_W-1:OFS_W-2] == 2'b10);
        rel    = {1'b0, ofs[ADDR_W-2:0]};
      end
      default: begin
        in_win = (ofs[OFS_W-1:OFS_W-2] == 2'b11);
        rel    = {1'b0, ofs[ADDR_W-2:0]};
      end
    endcase
  end
endmodule

// File: rtl/vga_addr_chain.sv
module vga_addr_chain #(
  parameter int ADDR_W = 16,
  localparam int OFS_W = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0] rel,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [1:0]        sel,
  input  logic              chain,
  input  logic              page,
  output logic [ADDR_W-1:0] addr
);
  logic low_bit;

  always_comb begin
    if (!chain)             low_bit = rel[0];
    else if (sel == 2'b00)  low_bit = ofs[OFS_W-1];
    else                    low_bit = page;
    addr = {rel[ADDR_W-1:1], low_bit};
  end
endmodule

// File: rtl/vga_plane_pick.sv
module vga_plane_pick #(
  parameter int PLANES = 4,
  localparam int IDX_W = $clog2(PLANES)
) (
  input  logic              a0,
  input  logic              wr_go,
  input  logic              flat,
  input  logic [PLANES-1:0] mask,
  input  logic              rd_oe,
  input  logic [IDX_W-1:0]  rd_sel,
  output logic [PLANES-1:0] wr_en,
  output logic [IDX_W-1:0]  rd_idx
);
  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    localparam bit ODD = (p % 2) == 1;
    assign wr_en[p] = wr_go & mask[p] & (flat | (a0 == ODD));
  end

  always_comb begin
    rd_idx = rd_sel;
    if (rd_oe) rd_idx[0] = a0;
  end
endmodule

// File: rtl/vga_host_plane_map.sv
module vga_host_plane_map #(
  parameter int ADDR_W = 16,
  parameter int PLANES = 4,
  localparam int OFS_W = ADDR_W + 1,
  localparam int IDX_W = $clog2(PLANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  host_ofs,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [PLANES-1:0] plane_mask,
  input  logic              wr_flat,
  input  logic [IDX_W-1:0]  rd_map,
  input  logic              rd_oddeven,
  input  logic [1:0]        map_win,
  input  logic              addr_chain,
  input  logic              page_hi,
  output logic              win_hit,
  output logic [ADDR_W-1:0] plane_addr,
  output logic [PLANES-1:0] plane_wr_en,
  output logic [IDX_W-1:0]  rd_plane
);
  logic              in_win;
  logic [ADDR_W-1:0] rel_ofs;
  logic [ADDR_W-1:0] mapped;
  logic [PLANES-1:0] we_d;
  logic [IDX_W-1:0]  rd_d;

  vga_win_decode #(.ADDR_W(ADDR_W)) u_win (
    .ofs(host_ofs), .sel(map_win), .in_win(in_win), .rel(rel_ofs)
  );

  vga_addr_chain #(.ADDR_W(ADDR_W)) u_chain (
    .rel(rel_ofs), .ofs(host_ofs), .sel(map_win),
    .chain(addr_chain), .page(page_hi), .addr(mapped)
  );

  vga_plane_pick #(.PLANES(PLANES)) u_pick (
    .a0(host_ofs[0]), .wr_go(wr_req & in_win), .flat(wr_flat),
    .mask(plane_mask), .rd_oe(rd_oddeven), .rd_sel(rd_map),
    .wr_en(we_d), .rd_idx(rd_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_hit     <= 1'b0;
      plane_addr  <= '0;
      plane_wr_en <= '0;
      rd_plane    <= '0;
    end else begin
      win_hit     <= in_win & (rd_req | wr_req);
      plane_addr  <= mapped;
      plane_wr_en <= we_d;
      rd_plane    <= rd_d;
    end
  end

  // R3: no plane is written without a window hit
  p_we_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (plane_wr_en != '0) |-> win_hit);

  // R5: odd/even writes keep to the parity-matched planes
  p_oe_parity_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_req) && !$past(wr_flat) && !$past(host_ofs[0]))
      |-> ((plane_wr_en & 4'b1010) == 4'b0000));

  // R4: flat writes follow the mask
  p_flat_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && win_hit && $past(wr_req) && $past(wr_flat))
      |-> (plane_wr_en == $past(plane_mask)));

  // R7: odd/even reads take host A0 as the low index bit
  p_rd_oddeven_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_oddeven)) |-> (rd_plane[0] == $past(host_ofs[0])));

  // R8: unchained address keeps host A0
  p_chain_off_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(addr_chain)) |-> (plane_addr[0] == $past(host_ofs[0])));

  // R10: chained small window takes the page bit
  p_page_bit_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr_chain) && ($past(map_win) != 2'b00))
      |-> (plane_addr[0] == $past(page_hi)));
endmodule

// File: tb/vga_host_plane_map_tb.sv
module vga_host_plane_map_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] host_ofs = '0;
  logic        rd_req = 1'b0, wr_req = 1'b0;
  logic [3:0]  plane_mask = '0;
  logic        wr_flat = 1'b0;
  logic [1:0]  rd_map = '0;
  logic        rd_oddeven = 1'b0;
  logic [1:0]  map_win = '0;
  logic        addr_chain = 1'b0, page_hi = 1'b0;
  logic        win_hit;
  logic [15:0] plane_addr;
  logic [3:0]  plane_wr_en;
  logic [1:0]  rd_plane;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vga_host_plane_map u_dut (
    .clk(clk), .rst(rst), .host_ofs(host_ofs), .rd_req(rd_req), .wr_req(wr_req),
    .plane_mask(plane_mask), .wr_flat(wr_flat), .rd_map(rd_map),
    .rd_oddeven(rd_oddeven), .map_win(map_win), .addr_chain(addr_chain),
    .page_hi(page_hi), .win_hit(win_hit), .plane_addr(plane_addr),
    .plane_wr_en(plane_wr_en), .rd_plane(rd_plane)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (ofs=%05h win=%0d chain=%0d page=%0d flat=%0d roe=%0d map=%0d mask=%0h rd=%0b wr=%0b)",
               req, act, exp, host_ofs, map_win, addr_chain, page_hi, wr_flat,
               rd_oddeven, rd_map, plane_mask, rd_req, wr_req);
    end
  endtask

  function automatic int offset_pick(input int i);
    case (i)
      0: return 17'h00000;  1: return 17'h00001;  2: return 17'h07FFF;
      3: return 17'h08000;  4: return 17'h0FFFE;  5: return 17'h0FFFF;
      6: return 17'h10000;  7: return 17'h10001;  8: return 17'h17FFF;
      9: return 17'h18000;  10: return 17'h1FFFF; default: return 17'h0A5C3;
    endcase
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset with every strobe and control active
    host_ofs = 17'h1FFFF; rd_req = 1; wr_req = 1; plane_mask = 4'hF; wr_flat = 1;
    rd_map = 2'b11; rd_oddeven = 1; addr_chain = 1; page_hi = 1;
    repeat (3) @(negedge clk);
    check("R1 hit", win_hit, 0);
    check("R1 addr", plane_addr, 0);
    check("R1 we", plane_wr_en, 0);
    check("R1 rdplane", rd_plane, 0);
    rst = 0;

    for (int w = 0; w < 4; w++)
    for (int c = 0; c < 2; c++)
    for (int pg = 0; pg < 2; pg++)
    for (int fl = 0; fl < 2; fl++)
    for (int ro = 0; ro < 2; ro++)
    for (int m = 0; m < 16; m++)
    for (int st = 0; st < 4; st++)
    for (int a = 0; a < 12; a++) begin
      int ofs, abs_a, lo, hi, rel, exp_addr, exp_we, exp_rd, rmap;
      bit inw, exp_hit;
      ofs = offset_pick(a);
      rmap = (m + a) % 4;
      @(negedge clk);
      host_ofs = ofs[16:0]; map_win = w[1:0]; addr_chain = c[0]; page_hi = pg[0];
      wr_flat = fl[0]; rd_oddeven = ro[0]; plane_mask = m[3:0]; rd_map = rmap[1:0];
      rd_req = st[0]; wr_req = st[1];
      @(posedge clk);
      @(negedge clk);
      abs_a = 'hA0000 + ofs;
      case (w)
        0: begin lo = 'hA0000; hi = 'hBFFFF; end
        1: begin lo = 'hA0000; hi = 'hAFFFF; end
        2: begin lo = 'hB0000; hi = 'hB7FFF; end
        default: begin lo = 'hB8000; hi = 'hBFFFF; end
      endcase
      inw = (abs_a >= lo) && (abs_a <= hi);
      exp_hit = inw && (st != 0);
      check("R2 hit", win_hit, exp_hit);
      rel = (abs_a - lo) % 65536;
      if (inw && st[1]) begin
        if (fl) begin
          exp_we = m;
          check("R4 we", plane_wr_en, exp_we);
        end else begin
          exp_we = m & ((ofs % 2) ? 'hA : 'h5);
          check("R5 we", plane_wr_en, exp_we);
        end
      end else begin
        check("R3 we", plane_wr_en, 0);
      end
      exp_rd = ro ? ((rmap / 2) * 2 + (ofs % 2)) : rmap;
      if (fl) check("R6 rdplane", rd_plane, exp_rd);
      else    check("R7 rdplane", rd_plane, exp_rd);
      if (exp_hit) begin
        if (!c) begin
          exp_addr = rel;
          check("R8 addr", plane_addr, exp_addr);
        end else if (w == 0) begin
          exp_addr = (rel / 2) * 2 + (ofs / 65536);
          check("R9 addr", plane_addr, exp_addr);
        end else begin
          exp_addr = (rel / 2) * 2 + pg;
          check("R10 addr", plane_addr, exp_addr);
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule